// File: doc/BRIEF.md
# Filtered Event Performance Counter

This block is one counting slot of an I/O address-translation performance monitor. Every clock cycle the translation logic may offer one event. The event carries an 8-bit event code and three requester tags: a 16-bit device ID, a 16-bit domain ID and a 20-bit address-space ID. The slot holds a 48-bit count. The count advances by one when the event code equals the programmed source select and every enabled ID filter accepts the tags.

Software reaches the slot through a flat register port. The port has a write strobe, a 3-bit register index and 64-bit write data. Read data is combinational on the register index. The slot has five registers: source select, counter, and one match register for each ID tag. A source select of zero turns the slot off. In that state counter writes are dropped and counter reads return zero, which mirrors a power-gated counter.

Top module: `evt_perf_slot`

## Requirements
- R1: After reset the source select (index 0), the counter (index 1) and the device (index 2), domain (index 3) and address-space (index 4) match registers all read as zero.
- R2: When a valid event's code equals a nonzero source select and every filter accepts it, the counter read at index 1 is one higher in the cycle after that event's clock edge.
- R3: While the source select is zero, no event is counted, a counter write has no effect on the held count, and counter reads return zero.
- R4: The counter is 48 bits wide and occupies read bits 47:0. Read bits 63:48 are always zero.
- R5: Each match register keeps its match value in the low bits (16 bits for device and domain, 20 bits for address space), its filter enable in bit 31 and its mask at bit 32 upward with the same width as the value. Unimplemented bits read as zero.
- R6: A filter whose enable bit is clear accepts every tag value.
- R7: An enabled filter accepts a tag when ((tag XOR value) AND NOT mask) is zero, so a set mask bit is a don't-care.
- R8: An event is counted only when all three filters accept it. A rejection by any one filter blocks the count.
- R9: The counter wraps from all ones to zero with no other effect.
- R10: A counter write in the same cycle as a counted event loads the written value, and the event is lost.
- R11: A valid event whose code differs from the source select does not change the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Register write strobe |
| reg_idx | input | 3 | Register index: 0 source, 1 counter, 2 device, 3 domain, 4 address space |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data of the register selected by reg_idx |
| ev_valid | input | 1 | An event is offered this cycle |
| ev_code | input | 8 | Event code |
| ev_dev | input | 16 | Device ID tag |
| ev_dom | input | 16 | Domain ID tag |
| ev_asid | input | 20 | Address-space ID tag |

## Verification
The bench targets counter writes made while the slot is disabled. A design that ignored the gate would show the stale written value once the source is set. It also targets a write and an event in the same cycle, where a wrong design reads one above the written value. The wrap from all ones must read zero; a design with the wrong width would read 2^48. The masked filter cases target two faults: a filter that ignores its mask rejects events it should accept, and filters combined with OR count events that one filter rejected. Random traffic around a partly matching device pattern then compares every sampled count with a bench model.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  localparam int DATA_W   = 64;
  localparam int SRC_W    = 8;
  localparam int CNT_W    = 48;
  localparam int DEV_W    = 16;
  localparam int DOM_W    = 16;
  localparam int ASID_W   = 20;
  localparam int IDX_W    = 3;
  localparam int EN_BIT   = 31;
  localparam int MASK_LSB = 32;

  typedef enum logic [IDX_W-1:0] {
    IDX_SRC  = 3'd0,
    IDX_CNT  = 3'd1,
    IDX_DEV  = 3'd2,
    IDX_DOM  = 3'd3,
    IDX_ASID = 3'd4
  } reg_idx_e;
endpackage

// File: rtl/pmc_match_reg.sv
module pmc_match_reg import pmc_pkg::*; #(
  parameter int W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  input  logic [W-1:0]      tag,
  output logic [DATA_W-1:0] rdata,
  output logic              accept
);
  logic         en_q, en_d;
  logic [W-1:0] val_q, val_d;
  logic [W-1:0] msk_q, msk_d;

  always_comb begin
    en_d  = en_q;
    val_d = val_q;
    msk_d = msk_q;
    if (we) begin
      en_d  = wdata[EN_BIT];
      val_d = wdata[W-1:0];
      msk_d = wdata[MASK_LSB +: W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      val_q <= '0;
      msk_q <= '0;
    end else if (we) begin
      en_q  <= en_d;
      val_q <= val_d;
      msk_q <= msk_d;
    end
  end

  always_comb begin
    rdata = '0;
    rdata[W-1:0]         = val_q;
    rdata[EN_BIT]        = en_q;
    rdata[MASK_LSB +: W] = msk_q;
  end

  assign accept = !en_q || (((tag ^ val_q) & ~msk_q) == '0);
endmodule

// File: rtl/pmc_counter.sv
module pmc_counter import pmc_pkg::*; (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             incr,
  output logic [CNT_W-1:0] count
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign cnt_en = load || incr;

  always_comb begin
    cnt_d = cnt_q;
    if (load)      cnt_d = load_val;
    else if (incr) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign count = cnt_q;
endmodule

// File: rtl/evt_perf_slot.sv
module evt_perf_slot import pmc_pkg::*; (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              reg_wr,
  input  logic [IDX_W-1:0]  reg_idx,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              ev_valid,
  input  logic [SRC_W-1:0]  ev_code,
  input  logic [DEV_W-1:0]  ev_dev,
  input  logic [DOM_W-1:0]  ev_dom,
  input  logic [ASID_W-1:0] ev_asid
);
  localparam int NFILT = 3;

  logic [1:0]       rst_sync_q;
  logic             rst_n;
  logic [SRC_W-1:0] src_q, src_d;
  logic             src_we, slot_on;
  logic [CNT_W-1:0] cnt_q;
  logic             cnt_load, cnt_incr;
  logic [NFILT-1:0] filt_we, filt_ok;
  logic [DATA_W-1:0] dev_rd, dom_rd, asid_rd;

  // reset: asserted asynchronously, released after two clock edges
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  assign src_we = reg_wr && (reg_idx == IDX_SRC);

  always_comb begin
    src_d = src_q;
    if (src_we) src_d = reg_wdata[SRC_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      src_q <= '0;
    else if (src_we) src_q <= src_d;
  end

  assign slot_on = (src_q != '0);

  assign filt_we[0] = reg_wr && (reg_idx == IDX_DEV);
  assign filt_we[1] = reg_wr && (reg_idx == IDX_DOM);
  assign filt_we[2] = reg_wr && (reg_idx == IDX_ASID);

  pmc_match_reg #(.W(DEV_W)) u_dev_filt (
    .clk(clk), .rst_n(rst_n), .we(filt_we[0]), .wdata(reg_wdata),
    .tag(ev_dev), .rdata(dev_rd), .accept(filt_ok[0]));

  pmc_match_reg #(.W(DOM_W)) u_dom_filt (
    .clk(clk), .rst_n(rst_n), .we(filt_we[1]), .wdata(reg_wdata),
    .tag(ev_dom), .rdata(dom_rd), .accept(filt_ok[1]));

  pmc_match_reg #(.W(ASID_W)) u_asid_filt (
    .clk(clk), .rst_n(rst_n), .we(filt_we[2]), .wdata(reg_wdata),
    .tag(ev_asid), .rdata(asid_rd), .accept(filt_ok[2]));

  assign cnt_load = reg_wr && (reg_idx == IDX_CNT) && slot_on;
  assign cnt_incr = ev_valid && slot_on && (ev_code == src_q) && (&filt_ok);

  pmc_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .load(cnt_load),
    .load_val(reg_wdata[CNT_W-1:0]), .incr(cnt_incr), .count(cnt_q));

  always_comb begin
    reg_rdata = '0;
    case (reg_idx)
      IDX_SRC:  reg_rdata[SRC_W-1:0] = src_q;
      IDX_CNT:  if (slot_on) reg_rdata[CNT_W-1:0] = cnt_q;
      IDX_DEV:  reg_rdata = dev_rd;
      IDX_DOM:  reg_rdata = dom_rd;
      IDX_ASID: reg_rdata = asid_rd;
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/evt_perf_slot_chk.sv
module evt_perf_slot_chk import pmc_pkg::*; (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [IDX_W-1:0]  reg_idx,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              ev_valid,
  input logic [SRC_W-1:0]  ev_code,
  input logic [SRC_W-1:0]  src_q,
  input logic [CNT_W-1:0]  cnt_q
);
  logic cnt_wr;
  assign cnt_wr = reg_wr && (reg_idx == IDX_CNT);

  assert_upper_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_idx == IDX_CNT) |-> (reg_rdata[DATA_W-1:CNT_W] == '0));

  assert_gated_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (src_q == '0 && reg_idx == IDX_CNT) |-> (reg_rdata == '0));

  assert_frozen_when_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (src_q == '0) |=> $stable(cnt_q));

  assert_single_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_wr |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 1'b1));

  assert_write_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_wr && src_q != '0) |=> (cnt_q == $past(reg_wdata[CNT_W-1:0])));

  assert_code_mismatch_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_wr && (!ev_valid || ev_code != src_q)) |=> $stable(cnt_q));
endmodule

bind evt_perf_slot evt_perf_slot_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_idx(reg_idx),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ev_valid(ev_valid),
  .ev_code(ev_code), .src_q(src_q), .cnt_q(cnt_q));

// File: tb/test_evt_perf_slot.sv
module test_evt_perf_slot;
  localparam int CLK_PERIOD = 10;

  logic        clk, arst_n;
  logic        reg_wr;
  logic [2:0]  reg_idx;
  logic [63:0] reg_wdata, reg_rdata;
  logic        ev_valid;
  logic [7:0]  ev_code;
  logic [15:0] ev_dev, ev_dom;
  logic [19:0] ev_asid;

  int vectors = 0, errors = 0;

  // bench model
  logic [7:0]  m_src;
  logic [47:0] m_cnt;
  logic [63:0] m_dev, m_dom, m_asid;

  evt_perf_slot i_evt_perf_slot (
    .clk(clk), .arst_n(arst_n), .reg_wr(reg_wr), .reg_idx(reg_idx),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ev_valid(ev_valid),
    .ev_code(ev_code), .ev_dev(ev_dev), .ev_dom(ev_dom), .ev_asid(ev_asid));

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic f_ok(input logic [63:0] r, input int w, input logic [19:0] tag);
    logic [19:0] val, msk, wm;
    wm  = 20'((64'd1 << w) - 1);
    val = r[19:0] & wm;
    msk = r[51:32] & wm;
    return !r[31] || ((((tag & wm) ^ val) & ~msk) == 20'd0);
  endfunction

  function automatic logic [63:0] keep_bits(input logic [63:0] d, input int w);
    logic [63:0] m;
    m = ((64'd1 << w) - 1) | (64'd1 << 31) | (((64'd1 << w) - 1) << 32);
    return d & m;
  endfunction

  function automatic logic [63:0] exp_read(input int idx);
    case (idx)
      0: return {56'd0, m_src};
      1: return (m_src == 8'd0) ? 64'd0 : {16'd0, m_cnt};
      2: return m_dev;
      3: return m_dom;
      4: return m_asid;
      default: return 64'd0;
    endcase
  endfunction

  task automatic idle();
    reg_wr = 0; reg_idx = 0; reg_wdata = 0; ev_valid = 0;
    ev_code = 0; ev_dev = 0; ev_dom = 0; ev_asid = 0;
  endtask

  // one clock cycle of stimulus; model follows the requirements
  task automatic cyc(input logic wr, input int idx, input logic [63:0] wd,
                     input logic ev, input logic [7:0] code,
                     input logic [15:0] dv, input logic [15:0] dm, input logic [19:0] as);
    logic hit;
    @(negedge clk);
    reg_wr = wr; reg_idx = 3'(idx); reg_wdata = wd;
    ev_valid = ev; ev_code = code; ev_dev = dv; ev_dom = dm; ev_asid = as;
    hit = ev && m_src != 0 && code == m_src &&
          f_ok(m_dev, 16, {4'd0, dv}) && f_ok(m_dom, 16, {4'd0, dm}) && f_ok(m_asid, 20, as);
    @(posedge clk);
    if (wr && idx == 1 && m_src != 0) m_cnt = wd[47:0];
    else if (hit) m_cnt = m_cnt + 48'd1;
    if (wr && idx == 0) m_src = wd[7:0];
    if (wr && idx == 2) m_dev = keep_bits(wd, 16);
    if (wr && idx == 3) m_dom = keep_bits(wd, 16);
    if (wr && idx == 4) m_asid = keep_bits(wd, 20);
  endtask

  task automatic wreg(input int idx, input logic [63:0] wd);
    cyc(1'b1, idx, wd, 1'b0, 8'd0, 16'd0, 16'd0, 20'd0);
  endtask

  task automatic evt(input logic [7:0] code, input logic [15:0] dv,
                     input logic [15:0] dm, input logic [19:0] as);
    cyc(1'b0, 0, 64'd0, 1'b1, code, dv, dm, as);
  endtask

  task automatic chk(input int idx, input logic [63:0] exp, input string req);
    @(negedge clk);
    idle();
    reg_idx = 3'(idx);
    #1;
    vectors++;
    if (reg_rdata !== exp) begin
      errors++;
      $display("FAIL %s idx %0d: actual %h expected %h", req, idx, reg_rdata, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    m_src = 0; m_cnt = 0; m_dev = 0; m_dom = 0; m_asid = 0;
    idle();
    arst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); arst_n = 1;
    repeat (4) @(posedge clk);

    // R1 reset values
    for (int i = 0; i < 5; i++) chk(i, 64'd0, "R1");

    // R5 match register layout
    wreg(2, 64'hFFFF_00FF_8000_1234);
    chk(2, 64'h0000_00FF_8000_1234, "R5");
    wreg(4, 64'hFFFF_FFFF_FFFF_FFFF);
    chk(4, 64'h000F_FFFF_800F_FFFF, "R5");
    wreg(2, 64'd0); wreg(4, 64'd0);

    // R3 disabled slot: write ignored, no counting
    wreg(1, 64'd123);
    evt(8'd0, 16'd0, 16'd0, 20'd0);
    chk(1, 64'd0, "R3");
    wreg(0, 64'd3);
    chk(1, 64'd0, "R3");

    // R2 / R11 / R4 / R6
    evt(8'd3, 16'hABCD, 16'h1111, 20'h54321);
    chk(1, 64'd1, "R2");
    evt(8'd4, 16'd0, 16'd0, 20'd0);
    chk(1, 64'd1, "R11");
    evt(8'd3, 16'h0001, 16'hFFFF, 20'hFFFFF);
    chk(1, 64'd2, "R6");

    // R3 read gating with held value
    wreg(0, 64'd0);
    chk(1, 64'd0, "R3");
    wreg(0, 64'd3);
    chk(1, 64'd2, "R3");

    // R10 write beats event
    cyc(1'b1, 1, 64'd100, 1'b1, 8'd3, 16'd0, 16'd0, 20'd0);
    chk(1, 64'd100, "R10");

    // R9 wrap, R4 upper bits
    wreg(1, 64'hFFFF_FFFF_FFFF_FFFF);
    chk(1, 64'h0000_FFFF_FFFF_FFFF, "R4");
    evt(8'd3, 16'd0, 16'd0, 20'd0);
    chk(1, 64'd0, "R9");

    // R7 masked compare on device
    wreg(2, 64'h0000_00FF_8000_1200);
    evt(8'd3, 16'h12A5, 16'd0, 20'd0);
    chk(1, 64'd1, "R7");
    evt(8'd3, 16'h13A5, 16'd0, 20'd0);
    chk(1, 64'd1, "R7");

    // R8 all filters must accept
    wreg(3, 64'h0000_0000_8000_0042);
    wreg(4, 64'h0000_000F_8000_7770);
    evt(8'd3, 16'h1200, 16'h0042, 20'h7775);
    chk(1, 64'd2, "R8");
    evt(8'd3, 16'h1200, 16'h0043, 20'h7775);
    chk(1, 64'd2, "R8");
    evt(8'd3, 16'h1200, 16'h0042, 20'h7785);
    chk(1, 64'd2, "R8");

    // random traffic (R2 R7 R8 R10 R11)
    for (int ep = 0; ep < 40; ep++) begin
      logic [7:0] s;
      s = 8'($urandom_range(1, 24));
      wreg(0, {56'd0, s});
      wreg(2, {16'd0, 16'($urandom), 1'b1, 15'd0, 16'h12_00 | 16'($urandom_range(0, 255))});
      wreg(3, ($urandom % 2) ? 64'd0 : {16'd0, 16'hFF00, 1'b1, 15'd0, 16'h0055});
      wreg(4, 64'd0);
      for (int c = 0; c < 200; c++) begin
        logic [15:0] dv, dm;
        logic [7:0] cd;
        logic wr;
        dv = ($urandom % 2) ? {8'h12, 8'($urandom)} : 16'($urandom);
        dm = ($urandom % 2) ? {8'($urandom), 8'h55} : 16'($urandom);
        cd = ($urandom % 3 != 0) ? s : 8'($urandom_range(0, 24));
        wr = ($urandom % 50) == 0;
        cyc(wr, 1, {16'd0, 48'($urandom)}, ($urandom % 4) != 0, cd, dv, dm, 20'($urandom));
        if (c % 20 == 19) chk(1, exp_read(1), "R2");
      end
      for (int i = 0; i < 5; i++) chk(i, exp_read(i), "R5");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule